// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. The host enables the converter and sets a start/busy bit. The sequencer then keeps the sample switch closed for a programmable number of conversion-clock periods so the input can settle. After that it opens the switch and walks a trial code on the capacitor DAC from the most significant bit downward. At each step it reads a single comparator decision that says whether the DAC value is above the input.

The pace is set by a single-cycle conversion-clock enable, `tadTick`, which is produced outside the block. A completed conversion loads the result register, clears the busy bit and raises a sticky done flag. Clearing the start bit before completion abandons the conversion and leaves the result register untouched. Completion and abort both lead into a fixed two-cycle discharge lockout. The capacitor array is emptied during that window, and no new acquisition may begin until it ends.

Top module: `sar_seq`

## Requirements
- R1: The acquisition select picks how many `tadTick` periods of acquisition come before conversion: code 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. A whole conversion then takes that many ticks plus 11.
- R2: The first conversion period only holds the sample. Each of the next ten periods resolves one result bit, going from bit 9 down to bit 0. When `cmpHigh` is 1 whenever the DAC code is greater than an input value V, the result equals V.
- R3: On the tick that ends the hold period, `dacCode` becomes 0x200, which is the trial bit 9 alone.
- R4: `sampleClosed` is 1 in idle and during acquisition, 0 while converting, and 1 again from the completion onward.
- R5: On the final conversion tick, the result register is loaded, `busy` falls and `doneFlag` rises, all at the same clock edge.
- R6: A one-cycle `startClr` pulse during acquisition or conversion drops `busy` at the next edge. In that case `result` keeps its previous value and `doneFlag` stays low.
- R7: After every completion or abort, `dischargeOn` is 1 for exactly two clock cycles. No acquisition or conversion starts inside that window.
- R8: A `startSet` pulse is ignored if `enable` was low in the cycle before it. A pulse given in the same cycle that `enable` rises leaves `busy` at 0.
- R9: A host write (`hostWrEn`) loads `hostWrData` into `result` at the next edge. If a completion happens in the same cycle, the converted value wins.
- R10: `doneFlag` stays at 1 until a `doneClr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter power/enable |
| startSet | input | 1 | Host pulse that sets the start/busy bit |
| startClr | input | 1 | Host pulse that clears the start/busy bit (abort) |
| acqSel | input | 3 | Acquisition-time select |
| tadTick | input | 1 | Single-cycle conversion-clock enable |
| cmpHigh | input | 1 | Comparator: DAC code above input |
| hostWrEn | input | 1 | Host write strobe for the result register |
| hostWrData | input | 10 | Host write data |
| doneClr | input | 1 | Host pulse that clears the done flag |
| busy | output | 1 | Start/busy bit |
| sampleClosed | output | 1 | Sample switch closed (tracking input) |
| dischargeOn | output | 1 | Capacitor-array discharge active |
| dacCode | output | 10 | SAR trial code to the DAC |
| result | output | 10 | Conversion result register |
| doneFlag | output | 1 | Sticky completion flag |

## Verification
The assertions take for granted the following about the inputs: `tadTick`, `startSet`, `startClr`, `hostWrEn` and `doneClr` are single-cycle pulses, and `cmpHigh` is a settled function of the current `dacCode`. The bench drives every strobe for one cycle between falling edges. It derives `cmpHigh` combinationally from a fixed reference value held for the whole conversion. It spaces ticks several clocks apart, so no two control strobes fall in the same cycle except where the priority cases call for it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W  = 10;
  localparam int STEP_W = $clog2(RES_W + 1);
  localparam int SEL_W  = 3;
  localparam int ACQ_W  = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV, ST_LOCK} seqState_t;

  // control strobes handed to the datapath
  typedef struct packed {
    logic              dacClear;
    logic              dacStep;
    logic [STEP_W-1:0] stepIdx;
    logic              loadRes;
  } dpCtl_t;

  function automatic logic [ACQ_W-1:0] acqTads(input logic [SEL_W-1:0] sel);
    logic [ACQ_W-1:0] n;
    case (sel)
      3'd0: n = 5'd0;
      3'd1: n = 5'd2;
      3'd2: n = 5'd4;
      3'd3: n = 5'd6;
      3'd4: n = 5'd8;
      3'd5: n = 5'd12;
      3'd6: n = 5'd16;
      default: n = 5'd20;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int LOCK_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             startSet,
  input  logic             startClr,
  input  logic [SEL_W-1:0] acqSel,
  input  logic             tadTick,
  output logic             busy,
  output logic             sampleClosed,
  output logic             dischargeOn,
  output dpCtl_t           ctl
);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  seqState_t         state;
  logic              enPrev;
  logic              goBit;
  logic [ACQ_W-1:0]  acqCnt;
  logic [STEP_W-1:0] tadIdx;
  logic [LOCK_W-1:0] lockCnt;

  logic [ACQ_W-1:0]  acqTarget;
  logic              convLast;
  logic              abortReq;
  logic              startOk;
  logic              acqDone;

  always_comb begin
    acqTarget = acqTads(acqSel);
    convLast  = (state == ST_CONV) && tadTick && (tadIdx == STEP_W'(RES_W));
    abortReq  = startClr && goBit && ((state == ST_ACQ) || (state == ST_CONV)) && !convLast;
    startOk   = startSet && enable && enPrev && !goBit;
    acqDone   = tadTick && ((acqCnt + 1'b1) >= acqTarget);
  end

  always_comb begin
    ctl.dacClear = (state != ST_CONV);
    ctl.dacStep  = (state == ST_CONV) && tadTick && !abortReq;
    ctl.stepIdx  = tadIdx;
    ctl.loadRes  = convLast;
  end

  assign busy         = goBit;
  assign sampleClosed = (state != ST_CONV);
  assign dischargeOn  = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      goBit  <= 1'b0;
    end else begin
      enPrev <= enable;
      if (convLast)      goBit <= 1'b0;
      else if (startClr) goBit <= 1'b0;
      else if (startOk)  goBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      acqCnt  <= '0;
      tadIdx  <= '0;
      lockCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (goBit) begin
            acqCnt <= '0;
            tadIdx <= '0;
            state  <= (acqTarget == '0) ? ST_CONV : ST_ACQ;
          end
        end
        ST_ACQ: begin
          if (abortReq) begin
            state   <= ST_LOCK;
            lockCnt <= '0;
          end else if (acqDone) begin
            state  <= ST_CONV;
            tadIdx <= '0;
          end else if (tadTick) begin
            acqCnt <= acqCnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (abortReq || convLast) begin
            state   <= ST_LOCK;
            lockCnt <= '0;
          end else if (tadTick) begin
            tadIdx <= tadIdx + 1'b1;
          end
        end
        default: begin
          if (lockCnt == LOCK_W'(LOCK_CYC - 1)) begin
            state   <= ST_IDLE;
            lockCnt <= '0;
          end else begin
            lockCnt <= lockCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRes |=> !busy);

  // R7
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK) |=> (state == ST_LOCK) || (state == ST_IDLE));

  // R7
  no_start_in_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dischargeOn |=> !(state == ST_ACQ || state == ST_CONV));
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             cmpHigh,
  input  logic             hostWrEn,
  input  logic [RES_W-1:0] hostWrData,
  input  logic             doneClr,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result,
  output logic             doneFlag
);
  logic [RES_W-1:0] dacNext;

  // resolve the bit tried in the ending period, then try the next one
  always_comb begin
    dacNext = dacCode;
    for (int b = 0; b < RES_W; b++) begin
      if ((ctl.stepIdx != '0) && (b == RES_W - int'(ctl.stepIdx)) && cmpHigh)
        dacNext[b] = 1'b0;
      if (b == RES_W - 1 - int'(ctl.stepIdx))
        dacNext[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode  <= '0;
      result   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (ctl.dacClear)     dacCode <= '0;
      else if (ctl.dacStep) dacCode <= dacNext;

      if (ctl.loadRes)      result <= dacNext;
      else if (hostWrEn)    result <= hostWrData;

      if (ctl.loadRes)      doneFlag <= 1'b1;
      else if (doneClr)     doneFlag <= 1'b0;
    end
  end

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadRes && !hostWrEn) |=> $stable(result));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !doneClr) |=> doneFlag);

  // R3
  trial_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dacStep && ctl.stepIdx == '0) |=> (dacCode == RES_W'(1) << (RES_W - 1)));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             startSet,
  input  logic             startClr,
  input  logic [SEL_W-1:0] acqSel,
  input  logic             tadTick,
  input  logic             cmpHigh,
  input  logic             hostWrEn,
  input  logic [RES_W-1:0] hostWrData,
  input  logic             doneClr,
  output logic             busy,
  output logic             sampleClosed,
  output logic             dischargeOn,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result,
  output logic             doneFlag
);
  dpCtl_t ctl;

  sar_seq_ctrl #(.LOCK_CYC(2)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startSet(startSet),
    .startClr(startClr), .acqSel(acqSel), .tadTick(tadTick),
    .busy(busy), .sampleClosed(sampleClosed), .dischargeOn(dischargeOn),
    .ctl(ctl)
  );

  sar_seq_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmpHigh(cmpHigh),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .doneClr(doneClr),
    .dacCode(dacCode), .result(result), .doneFlag(doneFlag)
  );
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, startSet = 1'b0, startClr = 1'b0;
  logic [2:0] acqSel = 3'd0;
  logic       tadTick = 1'b0, cmpHigh;
  logic       hostWrEn = 1'b0, doneClr = 1'b0;
  logic [9:0] hostWrData = '0;
  logic       busy, sampleClosed, dischargeOn, doneFlag;
  logic [9:0] dacCode, result;
  logic [9:0] vin = '0;

  int checks = 0, fails = 0;
  logic [9:0] expQ[$];
  logic donePrev = 1'b0;
  bit finished = 0;
  int acqTab[8] = '{0, 2, 4, 6, 8, 12, 16, 20};

  always #5 clk = ~clk;
  assign cmpHigh = (dacCode > vin);

  sar_seq uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: each new done pops an expected result
  always @(negedge clk) begin
    if (rstN && doneFlag && !donePrev) begin
      if (expQ.size() == 0) check(0, "R5 unexpected done", result, 0);
      else begin
        logic [9:0] e;
        e = expQ.pop_front();
        check(result == e, "R2 result", result, e);
      end
    end
    donePrev = doneFlag;
  end

  task automatic tick();
    @(negedge clk) tadTick = 1'b1;
    @(negedge clk) tadTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) startSet = 1'b1;
    @(negedge clk) startSet = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearDone();
    @(negedge clk) doneClr = 1'b1;
    @(negedge clk) doneClr = 1'b0;
  endtask

  task automatic runConv(input logic [2:0] sel, input logic [9:0] v);
    int n = 0;
    acqSel = sel; vin = v;
    expQ.push_back(v);
    pulseStart();
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    while (busy && n < 60) begin tick(); n++; end
    check(n == acqTab[sel] + 11, "R1 tick count", n, acqTab[sel] + 11);
    check(doneFlag == 1'b1, "R5 done set", doneFlag, 1);
    check(sampleClosed == 1'b1, "R4 switch closed after completion", sampleClosed, 1);
    repeat (3) @(negedge clk);
    clearDone();
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [9:0] prev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && result == 0 && doneFlag == 0 && sampleClosed == 1 && dischargeOn == 0,
          "reset state", {busy, doneFlag, dischargeOn}, 0);

    // R8: start in the cycle enable rises is ignored
    @(negedge clk) begin enable = 1'b1; startSet = 1'b1; end
    @(negedge clk) startSet = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R8 same-cycle start ignored", busy, 0);

    // R1 R2 R5 across select codes and values
    runConv(3'd0, 10'h2AB);
    runConv(3'd2, 10'h3FF);
    runConv(3'd1, 10'h000);
    runConv(3'd7, 10'h155);
    runConv(3'd5, 10'h200);
    runConv(3'd3, 10'h1FF);
    runConv(3'd4, 10'h001);
    runConv(3'd6, 10'h0F0);

    // R4 during acquisition, R3 trial code, R7 lockout window
    acqSel = 3'd1; vin = 10'h321; expQ.push_back(10'h321);
    pulseStart();
    check(sampleClosed == 1'b1, "R4 closed in acquisition", sampleClosed, 1);
    tick(); tick();
    tick();
    check(sampleClosed == 1'b0, "R4 open in conversion", sampleClosed, 0);
    check(dacCode == 10'h200, "R3 first trial", dacCode, 10'h200);
    for (int i = 0; i < 9; i++) tick();
    @(negedge clk) tadTick = 1'b1;
    @(negedge clk) tadTick = 1'b0;
    check(dischargeOn && !busy, "R7 discharge cycle 1", dischargeOn, 1);
    @(negedge clk);
    check(dischargeOn == 1'b1, "R7 discharge cycle 2", dischargeOn, 1);
    @(negedge clk);
    check(dischargeOn == 1'b0, "R7 discharge ends", dischargeOn, 0);
    // R10 sticky
    repeat (5) @(negedge clk);
    check(doneFlag == 1'b1, "R10 done sticky", doneFlag, 1);
    clearDone();
    @(negedge clk);
    check(doneFlag == 1'b0, "R10 done cleared", doneFlag, 0);

    // R6 abort mid-conversion
    prev = result;
    acqSel = 3'd1; vin = 10'h0F0;
    pulseStart();
    for (int i = 0; i < 5; i++) tick();
    @(negedge clk) startClr = 1'b1;
    @(negedge clk) startClr = 1'b0;
    check(busy == 1'b0, "R6 busy dropped", busy, 0);
    check(dischargeOn == 1'b1, "R7 discharge after abort", dischargeOn, 1);
    repeat (4) @(negedge clk);
    check(result == prev, "R6 result kept", result, prev);
    check(doneFlag == 1'b0, "R6 no done", doneFlag, 0);

    // R9 host write while idle
    @(negedge clk) begin hostWrEn = 1'b1; hostWrData = 10'h123; end
    @(negedge clk) hostWrEn = 1'b0;
    check(result == 10'h123, "R9 host write", result, 10'h123);

    // R9 completion beats host write
    acqSel = 3'd0; vin = 10'h0AA; expQ.push_back(10'h0AA);
    pulseStart();
    for (int i = 0; i < 10; i++) tick();
    @(negedge clk) begin tadTick = 1'b1; hostWrEn = 1'b1; hostWrData = 10'h3C3; end
    @(negedge clk) begin tadTick = 1'b0; hostWrEn = 1'b0; end
    check(result == 10'h0AA, "R9 completion priority", result, 10'h0AA);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5 all results seen", expQ.size(), 0);
    summary();
  end
endmodule